// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block performs add and subtract on packed data. Two operand words are each split into independent byte lanes or halfword lanes, and one result word comes back. The lanes never pass a carry or a borrow to one another. A 6-bit opcode sets four things: the lane width, the arithmetic flavour, the signedness and the operand form.

There are five arithmetic flavours:
- wrap-around
- signed clamping
- unsigned clamping
- signed averaging
- unsigned averaging

For halfword lanes, two exchange forms are also available. Each one pairs the upper half of one operand with the lower half of the other. The unit also offers a full-width signed clamping add and subtract.

A sticky flag records that some result was clamped. Only reset clears it. Undefined opcodes produce a zero result and raise an error output. The block is meant to sit in an execute stage. The result can be registered (the default) or left combinational.

Top module: `psimd_addsub`

## Requirements
- R1: The opcode fields are as follows.
  - Kind is op[5:3]: 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 signed average, 4 unsigned average, 5 full-width signed clamp.
  - Width is op[2]: 0 for byte lanes, 1 for halfword lanes.
  - Form is op[1:0]: 0 add, 1 subtract, 2 exchange add-subtract, 3 exchange subtract-add.

  Byte lanes wrap on their own with no carry between them: bytes 0x87858381 plus 0x08060402 give 0x8F8B8783.
- R2: Halfword lanes add and subtract on their own in wrap mode.
- R3: In the exchange add-subtract form, the upper lane is a.hi + b.lo and the lower lane is a.lo − b.hi. In the exchange subtract-add form, the upper lane is a.hi − b.lo and the lower lane is a.lo + b.hi. In wrap mode, 0x80078003 and 0x00040002 give 0x80097FFF with the first form.
- R4: Signed clamping limits each lane to its two's-complement range. The exchange add-subtract of 0x80078003 and 0x00040002 gives 0x80098000.
- R5: Unsigned clamping limits each lane to the range 0 to all-ones. The exchange add-subtract of 0xFFF80003 and 0x00040009 gives 0xFFFF0000.
- R6: Signed averaging gives the full-precision lane sum or difference, shifted right arithmetically by one. Halfwords 0x80038001 plus 0x00040002 give 0xC003C001.
- R7: Unsigned averaging shifts the full-precision lane result right by one, logically. The exchange add-subtract of 0x80078003 and 0x00040002 gives 0x40043FFF.
- R8: Kind 5 with width 0 is a full-width signed clamping add (form 0) or subtract (form 1). 0x80000000 + 0x80000002 gives 0x80000000, and 0x80000003 − 4 gives 0x80000000.
- R9: The following opcodes are undefined: kinds 6 and 7, byte width with forms 2 or 3, and kind 5 with width 1 or with forms 2 or 3. An undefined opcode yields a zero result with the illegal output high.
- R10: The saturation output goes high once any clamping mode actually limits a result. It stays high until reset. A wrap-around or averaging result never sets it.
- R11: After reset, the result, illegal and saturation outputs are all zero.
- R12: With the registered option, result and illegal appear on the clock edge after the inputs are applied, together with the saturation flag update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 6 | Operation code (kind, width, form) |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| res_o | output | DATA_W | Lane-wise result |
| illegal_o | output | 1 | Opcode is undefined |
| sat_o | output | 1 | Sticky clamp indicator |

## Verification
The bench builds the unit at DATA_W = 32 with the registered output, which gives four byte lanes and one exchange pair. That size makes all 64 opcode values cheap to sweep, including every undefined one. Operands are drawn from a palette of lane values that sit on the signed and unsigned overflow edges, so each clamp direction and each averaging sign case is reached in every lane position. Expected words come from integer arithmetic in the bench. The sticky flag is predicted cycle by cycle and is checked across a mid-run reset.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

   localparam int OP_W = 6;

   typedef enum logic [1:0] {
      F_ADD = 2'd0,
      F_SUB = 2'd1,
      F_ASX = 2'd2,
      F_SAX = 2'd3
   } form_e;

   typedef enum logic [1:0] {
      G_NONE = 2'd0,
      G_BYTE = 2'd1,
      G_HALF = 2'd2,
      G_WIDE = 2'd3
   } grp_e;

   typedef enum logic [1:0] {
      M_WRAP = 2'd0,
      M_SAT  = 2'd1,
      M_AVG  = 2'd2
   } lmode_e;

   typedef struct packed {
      logic   legal;
      grp_e   grp;
      lmode_e mode;
      logic   sgn;
      form_e  form;
   } dec_t;

endpackage

// File: rtl/psimd_decode.sv
module psimd_decode
   import psimd_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output dec_t            dec_o
);

   logic [2:0] kind;
   logic       half;
   form_e      form;

   assign kind = op_i[5:3];
   assign half = op_i[2];
   assign form = form_e'(op_i[1:0]);

   always_comb begin
      dec_o.legal = 1'b0;
      dec_o.grp   = G_NONE;
      dec_o.mode  = M_WRAP;
      dec_o.sgn   = 1'b0;
      dec_o.form  = form;
      case (kind)
         3'd0: begin dec_o.mode = M_WRAP; dec_o.sgn = 1'b0; end
         3'd1: begin dec_o.mode = M_SAT;  dec_o.sgn = 1'b1; end
         3'd2: begin dec_o.mode = M_SAT;  dec_o.sgn = 1'b0; end
         3'd3: begin dec_o.mode = M_AVG;  dec_o.sgn = 1'b1; end
         3'd4: begin dec_o.mode = M_AVG;  dec_o.sgn = 1'b0; end
         3'd5: begin dec_o.mode = M_SAT;  dec_o.sgn = 1'b1; end
         default: begin dec_o.mode = M_WRAP; dec_o.sgn = 1'b0; end
      endcase
      if (kind <= 3'd4) begin
         if (half) begin
            dec_o.legal = 1'b1;
            dec_o.grp   = G_HALF;
         end else if (form == F_ADD || form == F_SUB) begin
            dec_o.legal = 1'b1;
            dec_o.grp   = G_BYTE;
         end
      end else if (kind == 3'd5 && !half && (form == F_ADD || form == F_SUB)) begin
         dec_o.legal = 1'b1;
         dec_o.grp   = G_WIDE;
      end
   end

endmodule

// File: rtl/psimd_lane.sv
module psimd_lane
   import psimd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         sub_i,
   input  logic         sgn_i,
   input  lmode_e       mode_i,
   output logic [W-1:0] r_o,
   output logic         clamp_o
);

   localparam int E = W + 2;

   logic [E-1:0] xe, ye, s;
   logic [W-1:0] smax, smin, umax;
   logic         ovf_s, neg_u, big_u;

   assign xe   = sgn_i ? {{2{x_i[W-1]}}, x_i} : {2'b00, x_i};
   assign ye   = sgn_i ? {{2{y_i[W-1]}}, y_i} : {2'b00, y_i};
   assign s    = sub_i ? (xe - ye) : (xe + ye);

   assign smax = {1'b0, {(W-1){1'b1}}};
   assign smin = {1'b1, {(W-1){1'b0}}};
   assign umax = {W{1'b1}};

   assign ovf_s = s[W] ^ s[W-1];
   assign neg_u = s[E-1];
   assign big_u = s[W] & ~s[E-1];

   always_comb begin
      r_o     = s[W-1:0];
      clamp_o = 1'b0;
      case (mode_i)
         M_SAT: begin
            if (sgn_i) begin
               if (ovf_s) begin
                  r_o     = s[E-1] ? smin : smax;
                  clamp_o = 1'b1;
               end
            end else if (neg_u) begin
               r_o     = '0;
               clamp_o = 1'b1;
            end else if (big_u) begin
               r_o     = umax;
               clamp_o = 1'b1;
            end
         end
         M_AVG:   r_o = s[W:1];
         default: r_o = s[W-1:0];
      endcase
   end

endmodule

// File: rtl/psimd_addsub.sv
module psimd_addsub
   import psimd_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              illegal_o,
   output logic              sat_o
);

   localparam int NB = DATA_W / 8;
   localparam int NH = DATA_W / 16;

   if ((DATA_W % 32) != 0 || DATA_W < 32) begin : g_bad_width
      $error("psimd_addsub: DATA_W must be a positive multiple of 32");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("psimd_addsub: OUT_REG must be 0 or 1");
   end

   dec_t dec;

   psimd_decode u_dec (
      .op_i  (op_i),
      .dec_o (dec)
   );

   logic [DATA_W-1:0] byte_r, half_r, wide_r;
   logic [NB-1:0]     byte_cl;
   logic [NH-1:0]     half_cl;
   logic              wide_cl;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      psimd_lane #(.W(8)) u_lane (
         .x_i     (a_i[i*8 +: 8]),
         .y_i     (b_i[i*8 +: 8]),
         .sub_i   (dec.form == F_SUB),
         .sgn_i   (dec.sgn),
         .mode_i  (dec.mode),
         .r_o     (byte_r[i*8 +: 8]),
         .clamp_o (byte_cl[i])
      );
   end

   for (genvar i = 0; i < NH; i++) begin : g_half
      localparam bit UPPER = (i % 2) == 1;
      localparam int PI    = UPPER ? i - 1 : i + 1;
      logic        exch;
      logic        sub;
      logic [15:0] y;
      assign exch = (dec.form == F_ASX) || (dec.form == F_SAX);
      assign y    = exch ? b_i[PI*16 +: 16] : b_i[i*16 +: 16];
      assign sub  = (dec.form == F_SUB) ||
                    (dec.form == F_ASX && !UPPER) ||
                    (dec.form == F_SAX && UPPER);
      psimd_lane #(.W(16)) u_lane (
         .x_i     (a_i[i*16 +: 16]),
         .y_i     (y),
         .sub_i   (sub),
         .sgn_i   (dec.sgn),
         .mode_i  (dec.mode),
         .r_o     (half_r[i*16 +: 16]),
         .clamp_o (half_cl[i])
      );
   end

   psimd_lane #(.W(DATA_W)) u_wide (
      .x_i     (a_i),
      .y_i     (b_i),
      .sub_i   (dec.form == F_SUB),
      .sgn_i   (1'b1),
      .mode_i  (M_SAT),
      .r_o     (wide_r),
      .clamp_o (wide_cl)
   );

   logic [DATA_W-1:0] res_c;
   logic              clamp_c;
   logic              illegal_c;

   always_comb begin
      res_c   = '0;
      clamp_c = 1'b0;
      case (dec.grp)
         G_BYTE: begin res_c = byte_r; clamp_c = |byte_cl; end
         G_HALF: begin res_c = half_r; clamp_c = |half_cl; end
         G_WIDE: begin res_c = wide_r; clamp_c = wide_cl;  end
         default: ;
      endcase
   end

   assign illegal_c = ~dec.legal;

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o     <= '0;
            illegal_o <= 1'b0;
         end else begin
            res_o     <= res_c;
            illegal_o <= illegal_c;
         end
      end
   end else begin : g_comb
      assign res_o     = res_c;
      assign illegal_o = illegal_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sat_o <= 1'b0;
      else        sat_o <= sat_o | clamp_c;
   end

   assert_zero_on_bad_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (res_o == '0));

   assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sat_o |=> sat_o);

   assert_sticky_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_o) |-> $past(clamp_c));

   assert_avg_no_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.mode == M_AVG) |-> !clamp_c);

   assert_wrap_no_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.mode == M_WRAP) |-> !clamp_c);

endmodule

// File: tb/psimd_addsub_tb.sv
module psimd_addsub_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  op_i = '0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic [31:0] res_o;
   logic        illegal_o;
   logic        sat_o;

   int n_run = 0;
   int n_fail = 0;
   bit exp_sat = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   psimd_addsub #(.DATA_W(32), .OUT_REG(1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op_i),
      .a_i       (a_i),
      .b_i       (b_i),
      .res_o     (res_o),
      .illegal_o (illegal_o),
      .sat_o     (sat_o)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic longint ext(logic [31:0] v, int w, bit s);
      longint m = (longint'(1) << w) - 1;
      longint u = longint'(v) & m;
      if (s && u[w-1]) u = u - (longint'(1) << w);
      return u;
   endfunction

   function automatic longint lane_fn(int kind, int w, longint x, longint y, bit sub, output bit cl);
      longint v = sub ? x - y : x + y;
      longint m = (longint'(1) << w) - 1;
      longint hi, lo;
      cl = 1'b0;
      case (kind)
         1, 5: begin hi = (longint'(1) << (w-1)) - 1; lo = -(longint'(1) << (w-1)); end
         2:    begin hi = m; lo = 0; end
         default: begin hi = 0; lo = 0; end
      endcase
      if (kind == 1 || kind == 2 || kind == 5) begin
         if (v > hi) begin v = hi; cl = 1'b1; end
         if (v < lo) begin v = lo; cl = 1'b1; end
      end else if (kind == 3 || kind == 4) begin
         v = v >>> 1;
      end
      return v & m;
   endfunction

   function automatic bit legal_of(logic [5:0] op);
      int k = op[5:3];
      if (k <= 4) return op[2] || op[1:0] < 2;
      if (k == 5) return !op[2] && op[1:0] < 2;
      return 1'b0;
   endfunction

   function automatic string req_of(logic [5:0] op);
      if (!legal_of(op)) return "R9";
      case (int'(op[5:3]))
         0: return op[2] ? (op[1] ? "R3" : "R2") : "R1";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic model(logic [5:0] op, logic [31:0] a, logic [31:0] b,
                        output logic [31:0] r, output bit ill, output bit cl);
      int  k = op[5:3];
      int  f = op[1:0];
      bit  sg = (k == 1 || k == 3 || k == 5);
      bit  c;
      longint v;
      r = '0; cl = 1'b0; ill = !legal_of(op);
      if (ill) return;
      if (k == 5) begin
         v = lane_fn(5, 32, ext(a, 32, 1), ext(b, 32, 1), f == 1, c);
         r = v[31:0]; cl = c;
      end else if (!op[2]) begin
         for (int i = 0; i < 4; i++) begin
            v = lane_fn(k, 8, ext(a >> (8*i), 8, sg), ext(b >> (8*i), 8, sg), f == 1, c);
            r[8*i +: 8] = v[7:0]; cl |= c;
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            int  pi = (f >= 2) ? (i ^ 1) : i;
            bit  sb = (f == 1) || (f == 2 && i == 0) || (f == 3 && i == 1);
            v = lane_fn(k, 16, ext(a >> (16*i), 16, sg), ext(b >> (16*pi), 16, sg), sb, c);
            r[16*i +: 16] = v[15:0]; cl |= c;
         end
      end
   endtask

   task automatic apply(logic [5:0] op, logic [31:0] a, logic [31:0] b);
      op_i = op; a_i = a; b_i = b;
      @(negedge clk);
   endtask

   task automatic fixed(string req, logic [5:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] exp);
      apply(op, a, b);
      check(req, "vector", res_o, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      exp_sat = 1'b0;
      check("R11", "reset res", res_o, '0);
      check("R11", "reset illegal", {31'd0, illegal_o}, 32'd0);
      check("R11", "reset sat", {31'd0, sat_o}, 32'd0);
   endtask

   function automatic logic [7:0] pal(logic [2:0] s, logic [7:0] rnd);
      case (s)
         3'd0: return 8'h00;
         3'd1: return 8'h01;
         3'd2: return 8'h7F;
         3'd3: return 8'h80;
         3'd4: return 8'h81;
         3'd5: return 8'hFE;
         3'd6: return 8'hFF;
         default: return rnd;
      endcase
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr = 32'hACE1_2357;
      @(negedge clk);
      do_reset();

      // R1 byte wrap with no inter-lane carry (op 6'h00)
      fixed("R1", 6'h00, 32'h87858381, 32'h08060402, 32'h8F8B8783);
      // R2 halfword wrap subtract (op 6'h05)
      fixed("R2", 6'h05, 32'h00030006, 32'h00020004, 32'h00010002);
      // R3 exchange forms (op 6'h06, 6'h07)
      fixed("R3", 6'h06, 32'h80078003, 32'h00040002, 32'h80097FFF);
      fixed("R3", 6'h07, 32'h80038007, 32'h00020004, 32'h7FFF8009);
      // R4 signed clamp exchange (6'h0E), byte 0x80-0x08 (6'h09)
      fixed("R4", 6'h0E, 32'h80078003, 32'h00040002, 32'h80098000);
      fixed("R4", 6'h09, 32'h808B8783, 32'h08060402, 32'h80858381);
      // R5 unsigned clamp exchange (6'h16), byte subtract (6'h11)
      fixed("R5", 6'h16, 32'hFFF80003, 32'h00040009, 32'hFFFF0000);
      fixed("R5", 6'h11, 32'h080B0702, 32'h0F060408, 32'h00050300);
      // R6 signed average halfword (6'h1C)
      fixed("R6", 6'h1C, 32'h80038001, 32'h00040002, 32'hC003C001);
      // R7 unsigned average exchange (6'h26)
      fixed("R7", 6'h26, 32'h80078003, 32'h00040002, 32'h40043FFF);
      // R8 full-width signed clamp (6'h28 add, 6'h29 subtract)
      fixed("R8", 6'h28, 32'h80000000, 32'h80000002, 32'h80000000);
      fixed("R8", 6'h29, 32'h80000003, 32'h00000004, 32'h80000000);
      // R9 undefined code
      apply(6'h38, 32'h12345678, 32'h11111111);
      check("R9", "illegal res", res_o, '0);
      check("R9", "illegal flag", {31'd0, illegal_o}, 32'd1);

      // R10 wrap and averaging overflow leave the sticky flag low
      do_reset();
      apply(6'h00, 32'hFFFFFFFF, 32'h01010101);
      check("R10", "wrap no sat", {31'd0, sat_o}, 32'd0);
      apply(6'h1C, 32'h7FFF7FFF, 32'h7FFF7FFF);
      check("R10", "avg no sat", {31'd0, sat_o}, 32'd0);
      apply(6'h09, 32'h80000000, 32'h01000000);
      check("R10", "clamp sets sat", {31'd0, sat_o}, 32'd1);
      apply(6'h00, 32'h0, 32'h0);
      check("R10", "sat holds", {31'd0, sat_o}, 32'd1);

      // R12 registered timing: output stays until the next edge
      apply(6'h00, 32'h01020304, 32'h01010101);
      op_i = 6'h00; a_i = 32'h10000000; b_i = 32'h0;
      #5;
      check("R12", "before edge", res_o, 32'h02030405);
      @(negedge clk);
      check("R12", "after edge", res_o, 32'h10000000);

      // sweep every opcode over boundary operand pairs
      do_reset();
      for (int op = 0; op < 64; op++) begin
         for (int p = 0; p < 24; p++) begin
            logic [31:0] a, b, er;
            bit ei, ec;
            for (int i = 0; i < 4; i++) begin
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               a[8*i +: 8] = pal(lfsr[2:0], lfsr[15:8]);
               b[8*i +: 8] = pal(lfsr[5:3], lfsr[23:16]);
            end
            model(6'(op), a, b, er, ei, ec);
            exp_sat |= ec;
            apply(6'(op), a, b);
            check(req_of(6'(op)), "sweep res", res_o, er);
            check(legal_of(6'(op)) ? "R1" : "R9", "sweep illegal", {31'd0, illegal_o}, {31'd0, ei});
            check("R10", "sweep sat", {31'd0, sat_o}, {31'd0, exp_sat});
         end
      end

      do_reset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule